// File: doc/BRIEF.md
# Escaped Serial Configuration Command Parser

This block takes the byte stream of a UART receiver while a command-select input is low, assembles framed register commands, removes the escape encoding and carries out reads and writes on a small configuration store. Each byte must be one of 0x00–0x7F or one of the two markers. 0xFF opens a frame. 0xFE either marks the next byte as carrying value+128 or, when it comes first, marks the frame as a read. Answers leave as single bytes towards a UART transmitter: an acknowledge (0x06), with the address and the raw value for a read, or a negative acknowledge (0x15).

The store holds a volatile working copy of each setting and a persistent mirror that sits at a separate address range. The mirror keeps its contents through the working reset `rst_n` and is set to factory values only by `por_n`. After every working reset the volatile copies reload from the mirror, one entry per cycle, and then `cfg_loaded` rises. A mirror write holds the block busy for a set number of cycles. A six-byte read-only identifier can also be read. Writing a non-zero value to the sleep-control register puts the block to sleep. From then on it discards received bytes until it sees four 0xFF bytes in a row. That sequence clears the register and wakes the block.

Both byte interfaces use valid/ready. A byte transfers on a rising clock edge when valid and ready are both high. `rx_ready` is low in several cases: before the load completes, while an answer is still pending, while a mirror write is busy, and whenever `cmd_mode_n` is high and the block is awake. `tx_valid` and `tx_data` stay constant until `tx_ready` accepts the byte.

Top module: `cfg_cmd_parser`

## Requirements
- R1: When `rst_n` is released, `cfg_loaded` and `rx_ready` stay low while the 14 volatile registers load from the mirror, one per cycle. `cfg_loaded` then rises and stays high. Factory values include 0x03 at 0x4D/0x02 and 0x40 at 0x54/0x09.
- R2: The frame FF 02 FE A reads a readable address A. The answer is the three bytes 06, A, value. The value is sent unescaped, even when it is 0x80 or more.
- R3: The frame FF 02 A V, with A and V both below 0x80, writes V to a writable address A. The answer is 06.
- R4: The frame FF 03 A FE L, with L below 0x80, writes L+128 to A. The answer is 06.
- R5: A read of an address that maps nothing answers the single byte 15. So does a write to the identifier or to an unmapped address, and the stored values do not change.
- R6: Address 0x22+k (k = 0..5) reads byte k of the identifier parameter, counted from the most significant end, so 0x22 returns bits 47:40.
- R7: A write to a mirror address (0x00–0x0D) sets the busy state. The 06 answer waits until NV_BUSY_CYCLES cycles have passed, and `rx_ready` is low during that time. The volatile copy keeps its value until the next `rst_n` reload.
- R8: A 0xFF byte restarts framing at any point. Frames with a length byte other than 02 or 03, a raw byte of 0x80 or more in a data position, or a three-byte frame without FE in the middle are dropped with no answer.
- R9: While the block is awake and `cmd_mode_n` is high, `rx_ready` is low. A rise of `cmd_mode_n` part-way through a frame discards the partial frame.
- R10: A non-zero write to 0x58 raises `asleep` after the answer 06. While asleep, received bytes produce no answer. Four consecutive 0xFF bytes clear 0x58 and lower `asleep`. Any other byte restarts the count.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low. Sets the mirror to factory values and must be given together with rst_n |
| rst_n | input | 1 | Working reset, active low. Starts the volatile reload |
| cmd_mode_n | input | 1 | Low routes received bytes to this parser |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Parser accepts the byte |
| tx_valid | output | 1 | Answer byte valid |
| tx_data | output | 8 | Answer byte |
| tx_ready | input | 1 | Downstream accepts the answer byte |
| cfg_loaded | output | 1 | Volatile reload finished |
| asleep | output | 1 | Sleep-control register is non-zero |

## Verification
The bench goes after the escape rules with a value above 127 and a read-back of that raw value. An unescape that forgot the +128, or that escaped the answer, would return the wrong byte. A 0xFF inside a frame, bad length bytes and raw high bytes must give exactly one answer or none. A decoder that did not resynchronise would answer twice or answer garbage. The bench times the answer to a mirror write and then reloads the volatile copy after a working reset. It also breaks a frame by raising the select line, interrupts the wake sequence with a different byte, and stalls the answer path. A design that copied the mirror at once, kept stale frame state, woke early or changed an answer byte under stall would fail those checks.

// File: rtl/cfg_cmd_pkg.sv
package cfg_cmd_pkg;
  localparam logic [7:0] HDR_B = 8'hFF;
  localparam logic [7:0] ESC_B = 8'hFE;
  localparam logic [7:0] ACK_B = 8'h06;
  localparam logic [7:0] NAK_B = 8'h15;

  typedef enum logic [2:0] {D_HDR, D_LEN, D_B0, D_B1, D_B2} dec_st_t;

  // factory value of each mirror entry
  function automatic logic [7:0] nv_default(input int idx);
    case (idx)
      2:       return 8'h03;
      4:       return 8'h01;
      5:       return 8'h10;
      8:       return 8'h01;
      9:       return 8'h40;
      10:      return 8'h01;
      11:      return 8'h01;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cmd_decoder.sv
module cmd_decoder
  import cfg_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       cmd_vld,
  output logic       cmd_wr,
  output logic [7:0] cmd_addr,
  output logic [7:0] cmd_val
);
  dec_st_t    st_q;
  logic       len2_q;
  logic [7:0] b0_q;

  always_comb begin
    cmd_vld  = 1'b0;
    cmd_wr   = 1'b0;
    cmd_addr = b0_q;
    cmd_val  = byte_in;
    if (byte_vld && !flush && byte_in != HDR_B) begin
      case (st_q)
        D_B1: if (len2_q) begin
          if (b0_q == ESC_B && !byte_in[7]) begin
            cmd_vld  = 1'b1;
            cmd_addr = byte_in;
          end else if (!b0_q[7] && !byte_in[7]) begin
            cmd_vld = 1'b1;
            cmd_wr  = 1'b1;
          end
        end
        D_B2: if (!byte_in[7]) begin
          cmd_vld = 1'b1;
          cmd_wr  = 1'b1;
          cmd_val = {1'b1, byte_in[6:0]};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= D_HDR;
      len2_q <= 1'b0;
      b0_q   <= 8'h00;
    end else if (flush) begin
      st_q <= D_HDR;
    end else if (byte_vld) begin
      if (byte_in == HDR_B) begin
        st_q <= D_LEN;
      end else begin
        case (st_q)
          D_LEN: begin
            if (byte_in == 8'h02 || byte_in == 8'h03) begin
              len2_q <= (byte_in == 8'h02);
              st_q   <= D_B0;
            end else begin
              st_q <= D_HDR;
            end
          end
          D_B0: begin
            b0_q <= byte_in;
            st_q <= D_B1;
          end
          D_B1: st_q <= (!len2_q && !b0_q[7] && byte_in == ESC_B) ? D_B2 : D_HDR;
          default: st_q <= D_HDR;
        endcase
      end
    end
  end
endmodule

// File: rtl/cfg_store.sv
module cfg_store
  import cfg_cmd_pkg::*;
#(
  parameter int          NUM_CFG     = 14,
  parameter int          VOL_BASE    = 8'h4B,
  parameter int          NV_BASE     = 8'h00,
  parameter int          ID_BASE     = 8'h22,
  parameter int          ID_BYTES    = 6,
  parameter logic [47:0] ID_VALUE    = 48'h0012_3456_789A,
  parameter int          BUSY_CYCLES = 1600000,
  parameter int          SLEEP_IDX   = 13
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic [7:0] addr,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       wake_clr,
  output logic       rd_hit,
  output logic       wr_hit,
  output logic [7:0] rd_data,
  output logic       busy,
  output logic       loaded,
  output logic       asleep
);
  localparam int IDX_W  = (NUM_CFG > 1) ? $clog2(NUM_CFG) : 1;
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  logic [7:0]        nv_q  [NUM_CFG];
  logic [7:0]        vol_q [NUM_CFG];
  logic [IDX_W-1:0]  ld_idx;
  logic [BUSY_W-1:0] busy_cnt;
  logic              vol_hit, nv_hit, id_hit;
  int                a;

  always_comb begin
    a       = int'(addr);
    vol_hit = 1'b0;
    nv_hit  = 1'b0;
    id_hit  = 1'b0;
    rd_data = 8'h00;
    for (int i = 0; i < NUM_CFG; i++) begin
      if (a == VOL_BASE + i) begin
        vol_hit = 1'b1;
        rd_data = vol_q[i];
      end
      if (a == NV_BASE + i) begin
        nv_hit  = 1'b1;
        rd_data = nv_q[i];
      end
    end
    for (int k = 0; k < ID_BYTES; k++) begin
      if (a == ID_BASE + k) begin
        id_hit  = 1'b1;
        rd_data = ID_VALUE[8*(ID_BYTES-1-k) +: 8];
      end
    end
    rd_hit = vol_hit | nv_hit | id_hit;
    wr_hit = vol_hit | nv_hit;
  end

  // persistent mirror, one register per entry
  for (genvar g = 0; g < NUM_CFG; g++) begin : gen_nv
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                          nv_q[g] <= nv_default(g);
      else if (wr_en && a == NV_BASE + g)  nv_q[g] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      busy_cnt <= '0;
    end else if (wr_en && nv_hit) begin
      busy     <= 1'b1;
      busy_cnt <= BUSY_W'(BUSY_CYCLES - 1);
    end else if (busy) begin
      if (busy_cnt == '0) busy <= 1'b0;
      else                busy_cnt <= busy_cnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CFG; i++) vol_q[i] <= 8'h00;
      ld_idx <= '0;
      loaded <= 1'b0;
    end else if (!loaded) begin
      vol_q[ld_idx] <= nv_q[ld_idx];
      if (ld_idx == IDX_W'(NUM_CFG - 1)) loaded <= 1'b1;
      else                               ld_idx <= ld_idx + 1'b1;
    end else begin
      for (int i = 0; i < NUM_CFG; i++)
        if (wr_en && a == VOL_BASE + i) vol_q[i] <= wr_data;
      if (wake_clr) vol_q[SLEEP_IDX] <= 8'h00;
    end
  end

  assign asleep = (vol_q[SLEEP_IDX] != 8'h00);
endmodule

// File: rtl/wake_seq.sv
module wake_seq
  import cfg_cmd_pkg::*;
#(
  parameter int COUNT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       armed,
  input  logic       byte_vld,
  input  logic [7:0] byte_in,
  output logic       wake
);
  localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;
  logic [CW-1:0] cnt;

  assign wake = armed && byte_vld && byte_in == HDR_B && cnt == CW'(COUNT - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cnt <= '0;
    else if (!armed || wake)         cnt <= '0;
    else if (byte_vld)               cnt <= (byte_in == HDR_B) ? cnt + 1'b1 : '0;
  end
endmodule

// File: rtl/resp_seq.sv
module resp_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [1:0] load_len,
  input  logic [7:0] b0,
  input  logic [7:0] b1,
  input  logic [7:0] b2,
  input  logic       hold,
  input  logic       tx_ready,
  output logic       pend,
  output logic       tx_valid,
  output logic [7:0] tx_data
);
  logic [7:0] buf_q [3];
  logic [1:0] idx, len_q;

  assign tx_valid = pend & ~hold;
  assign tx_data  = buf_q[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= 1'b0;
      idx   <= '0;
      len_q <= '0;
      for (int i = 0; i < 3; i++) buf_q[i] <= 8'h00;
    end else if (load) begin
      pend     <= 1'b1;
      idx      <= '0;
      len_q    <= load_len;
      buf_q[0] <= b0;
      buf_q[1] <= b1;
      buf_q[2] <= b2;
    end else if (tx_valid && tx_ready) begin
      if (idx == len_q - 1'b1) pend <= 1'b0;
      else                     idx  <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/cfg_cmd_parser.sv
module cfg_cmd_parser
  import cfg_cmd_pkg::*;
#(
  parameter int          NUM_CFG        = 14,
  parameter int          VOL_BASE       = 8'h4B,
  parameter int          NV_BASE        = 8'h00,
  parameter int          ID_BASE        = 8'h22,
  parameter int          ID_BYTES       = 6,
  parameter logic [47:0] ID_VALUE       = 48'h0012_3456_789A,
  parameter int          NV_BUSY_CYCLES = 1600000,
  parameter int          SLEEP_IDX      = 13,
  parameter int          WAKE_COUNT     = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       cmd_mode_n,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       tx_valid,
  output logic [7:0] tx_data,
  input  logic       tx_ready,
  output logic       cfg_loaded,
  output logic       asleep
);
  logic       rx_fire, resp_pend, nv_busy, wake;
  logic       cmd_vld, cmd_wr, rd_hit, wr_hit;
  logic [7:0] cmd_addr, cmd_val, rd_data;
  logic [1:0] rsp_len;
  logic [7:0] rsp0;

  assign rx_ready = cfg_loaded & ~resp_pend & ~nv_busy & (asleep | ~cmd_mode_n);
  assign rx_fire  = rx_valid & rx_ready;

  cmd_decoder u_dec (
    .clk(clk), .rst_n(rst_n), .flush(asleep | cmd_mode_n),
    .byte_vld(rx_fire & ~asleep), .byte_in(rx_data),
    .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_val(cmd_val)
  );

  cfg_store #(
    .NUM_CFG(NUM_CFG), .VOL_BASE(VOL_BASE), .NV_BASE(NV_BASE), .ID_BASE(ID_BASE),
    .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE), .BUSY_CYCLES(NV_BUSY_CYCLES),
    .SLEEP_IDX(SLEEP_IDX)
  ) u_store (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .addr(cmd_addr),
    .wr_en(cmd_vld & cmd_wr & wr_hit), .wr_data(cmd_val), .wake_clr(wake),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .rd_data(rd_data), .busy(nv_busy),
    .loaded(cfg_loaded), .asleep(asleep)
  );

  wake_seq #(.COUNT(WAKE_COUNT)) u_wake (
    .clk(clk), .rst_n(rst_n), .armed(asleep & cfg_loaded),
    .byte_vld(rx_fire), .byte_in(rx_data), .wake(wake)
  );

  always_comb begin
    rsp_len = 2'd1;
    rsp0    = NAK_B;
    if (cmd_wr ? wr_hit : rd_hit) begin
      rsp0    = ACK_B;
      rsp_len = cmd_wr ? 2'd1 : 2'd3;
    end
  end

  resp_seq u_resp (
    .clk(clk), .rst_n(rst_n), .load(cmd_vld), .load_len(rsp_len),
    .b0(rsp0), .b1(cmd_addr), .b2(rd_data), .hold(nv_busy),
    .tx_ready(tx_ready), .pend(resp_pend), .tx_valid(tx_valid), .tx_data(tx_data)
  );
endmodule

// File: rtl/cfg_cmd_parser_chk.sv
module cfg_cmd_parser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_mode_n,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_ready,
  input logic       tx_valid,
  input logic [7:0] tx_data,
  input logic       tx_ready,
  input logic       cfg_loaded,
  input logic       asleep,
  input logic       nv_busy
);
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));

  a_r1_block_until_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_loaded |-> !rx_ready);

  a_r1_loaded_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_loaded |=> cfg_loaded);

  a_r7_busy_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    nv_busy |-> !rx_ready && !tx_valid);

  a_r9_select_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_mode_n && !asleep |-> !rx_ready);

  a_r10_wake_on_ff: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |-> $past(rx_valid && rx_ready && rx_data == 8'hFF));
endmodule

bind cfg_cmd_parser cfg_cmd_parser_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_mode_n(cmd_mode_n), .rx_valid(rx_valid),
  .rx_data(rx_data), .rx_ready(rx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
  .tx_ready(tx_ready), .cfg_loaded(cfg_loaded), .asleep(asleep), .nv_busy(nv_busy)
);

// File: tb/cfg_cmd_parser_test.sv
module cfg_cmd_parser_test;
  localparam int          BUSY = 40;
  localparam logic [47:0] IDV  = 48'hA1B2_C3D4_E5F6;

  logic       clk = 1'b0;
  logic       por_n = 1'b0, rst_n = 1'b0, cmd_mode_n = 1'b0;
  logic       rx_valid = 1'b0, tx_ready = 1'b1;
  logic [7:0] rx_data = 8'h00, tx_data;
  logic       rx_ready, tx_valid, cfg_loaded, asleep;

  int         errors = 0, checks = 0;
  logic [7:0] q[$];

  always #5 clk = ~clk;

  cfg_cmd_parser #(.ID_VALUE(IDV), .NV_BUSY_CYCLES(BUSY)) uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .cmd_mode_n(cmd_mode_n),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .cfg_loaded(cfg_loaded), .asleep(asleep)
  );

  always @(negedge clk) if (tx_valid && tx_ready) q.push_back(tx_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    while (!rx_ready) @(negedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic frame2(input logic [7:0] a, input logic [7:0] b);
    send(8'hFF); send(8'h02); send(a); send(b);
  endtask

  task automatic get_resp(input string tag, input int n, input logic [7:0] e0,
                          input logic [7:0] e1, input logic [7:0] e2);
    int w = 0;
    while (q.size() < n && w < 300) begin @(negedge clk); w++; end
    repeat (6) @(negedge clk);
    chk({tag, " count"}, q.size(), n);
    if (q.size() > 0) chk({tag, " byte0"}, q[0], e0);
    if (n > 1 && q.size() > 1) chk({tag, " byte1"}, q[1], e1);
    if (n > 2 && q.size() > 2) chk({tag, " byte2"}, q[2], e2);
    q.delete();
  endtask

  task automatic expect_none(input string tag);
    repeat (40) @(negedge clk);
    chk({tag, " no answer"}, q.size(), 0);
    q.delete();
  endtask

  task automatic do_reset(input bit por);
    int k;
    @(negedge clk);
    rst_n = 1'b0;
    if (por) por_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    por_n = 1'b1;
    @(negedge clk);
    chk("R1 loaded low after reset", cfg_loaded, 1'b0);
    chk("R1 rx_ready low while loading", rx_ready, 1'b0);
    k = 1;
    while (!cfg_loaded && k < 60) begin @(negedge clk); k++; end
    chk("R1 load takes 14 cycles", (k >= 13 && k <= 15), 1'b1);
  endtask

  task automatic t_defaults;
    frame2(8'hFE, 8'h4D); get_resp("R1 default 0x4D", 3, 8'h06, 8'h4D, 8'h03);
    frame2(8'hFE, 8'h09); get_resp("R2 read mirror 0x09", 3, 8'h06, 8'h09, 8'h40);
  endtask

  task automatic t_write_small;
    frame2(8'h51, 8'h2A); get_resp("R3 write ack", 1, 8'h06, 0, 0);
    frame2(8'hFE, 8'h51); get_resp("R3 readback", 3, 8'h06, 8'h51, 8'h2A);
  endtask

  task automatic t_write_escaped;
    send(8'hFF); send(8'h03); send(8'h50); send(8'hFE); send(8'h05);
    get_resp("R4 escaped write ack", 1, 8'h06, 0, 0);
    frame2(8'hFE, 8'h50); get_resp("R2 R4 raw high readback", 3, 8'h06, 8'h50, 8'h85);
  endtask

  task automatic t_invalid;
    frame2(8'hFE, 8'h30); get_resp("R5 bad read", 1, 8'h15, 0, 0);
    frame2(8'h22, 8'h01); get_resp("R5 id write", 1, 8'h15, 0, 0);
    frame2(8'h60, 8'h01); get_resp("R5 unmapped write", 1, 8'h15, 0, 0);
    frame2(8'hFE, 8'h22); get_resp("R5 R6 id unchanged", 3, 8'h06, 8'h22, IDV[47:40]);
    frame2(8'hFE, 8'h27); get_resp("R6 id last byte", 3, 8'h06, 8'h27, IDV[7:0]);
    frame2(8'hFE, 8'h24); get_resp("R6 id middle byte", 3, 8'h06, 8'h24, IDV[31:24]);
  endtask

  task automatic t_nv;
    int k;
    frame2(8'h09, 8'h20);
    k = 1;
    chk("R7 rx blocked during busy", rx_ready, 1'b0);
    while (!tx_valid && k < 200) begin @(negedge clk); k++; end
    chk("R7 ack after busy time", (k >= BUSY && k <= BUSY + 2), 1'b1);
    get_resp("R7 mirror write ack", 1, 8'h06, 0, 0);
    frame2(8'hFE, 8'h54); get_resp("R7 volatile unchanged", 3, 8'h06, 8'h54, 8'h40);
    frame2(8'hFE, 8'h09); get_resp("R7 mirror holds", 3, 8'h06, 8'h09, 8'h20);
    do_reset(1'b0);
    frame2(8'hFE, 8'h54); get_resp("R7 reload after reset", 3, 8'h06, 8'h54, 8'h20);
  endtask

  task automatic t_malformed;
    send(8'hFF); send(8'h02); send(8'hFF); send(8'h02); send(8'hFE); send(8'h4D);
    get_resp("R8 restart on 0xFF", 3, 8'h06, 8'h4D, 8'h03);
    send(8'hFF); send(8'h05); send(8'h4B); send(8'h01);
    expect_none("R8 bad length");
    frame2(8'h4B, 8'h90);
    expect_none("R8 raw high byte");
    send(8'hFF); send(8'h03); send(8'h4B); send(8'h10); send(8'h20);
    expect_none("R8 missing escape");
    frame2(8'hFE, 8'h4B); get_resp("R8 no change", 3, 8'h06, 8'h4B, 8'h00);
  endtask

  task automatic t_cmd_select;
    send(8'hFF); send(8'h02);
    @(negedge clk); cmd_mode_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R9 rx blocked in data mode", rx_ready, 1'b0);
    cmd_mode_n = 1'b0;
    send(8'hFE); send(8'h4B);
    expect_none("R9 partial frame dropped");
    frame2(8'hFE, 8'h4E); get_resp("R9 resumes", 3, 8'h06, 8'h4E, 8'h00);
  endtask

  task automatic t_sleep;
    frame2(8'h58, 8'h01); get_resp("R10 sleep write ack", 1, 8'h06, 0, 0);
    chk("R10 asleep set", asleep, 1'b1);
    frame2(8'hFE, 8'h4B);
    expect_none("R10 ignored while asleep");
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'h05);
    repeat (3) @(negedge clk);
    chk("R10 broken sequence keeps sleep", asleep, 1'b1);
    send(8'hFF); send(8'hFF); send(8'hFF); send(8'hFF);
    @(negedge clk);
    chk("R10 woken", asleep, 1'b0);
    chk("R10 no answer to wake", q.size(), 0);
    frame2(8'hFE, 8'h58); get_resp("R10 sleep reg cleared", 3, 8'h06, 8'h58, 8'h00);
  endtask

  task automatic t_backpressure;
    @(posedge clk); #2 tx_ready = 1'b0;
    frame2(8'hFE, 8'h4D);
    repeat (10) @(negedge clk);
    chk("R11 valid held", tx_valid, 1'b1);
    chk("R11 data held", tx_data, 8'h06);
    chk("R11 nothing taken", q.size(), 0);
    @(posedge clk); #2 tx_ready = 1'b1;
    get_resp("R11 after release", 3, 8'h06, 8'h4D, 8'h03);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset(1'b1);
    t_defaults();
    t_write_small();
    t_write_escaped();
    t_invalid();
    t_malformed();
    t_cmd_select();
    t_sleep();
    t_backpressure();
    t_nv();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule